// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is a read-only bit store that hands a configuration bitstream to a device being configured, one bit for every clock. An internal address counter selects the bit on the data output. The counter moves only while the chip is selected and its combined reset/output-enable pin is in the enable state. A parameter sets which level of that pin means reset. Contents are loaded through a small synchronous write port that is honoured only while reset is held.

The data output is a value plus a separate drive-enable, so that several copies can share one data line. Each copy has a chip-enable-out pin that goes low once its own contents are used up. That pin feeds the chip-enable of the next copy, so a chain of stores on one clock and one data line gives out the concatenation of their contents in order. When a store is used up it stops counting and releases the data line. Its chip-enable-out then stays low, following its own chip-enable, until a reset.

Top module: `cfg_bitstore`

## Requirements
- R1: On a rising clock edge with the chip selected (ce_n low), reset inactive and the store not used up, the address advances by one. In any other case it does not advance.
- R2: With RST_ACTIVE_HIGH = 1, rst_oe high means reset. With RST_ACTIVE_HIGH = 0, rst_oe low means reset. Both variants behave identically apart from that level.
- R3: A clock edge with reset active returns the address to 0 and clears the used-up state. While reset is active, dout_en is 0 and ceo_n is 1.
- R4: While ce_n is high, dout_en is 0, ceo_n is 1 and standby is 1, whatever rst_oe does. The address does not move unless reset is active.
- R5: dout_en is 1 only when the chip is selected, reset is inactive and the store is not used up. dout then carries the stored bit at the current address, starting from address 0 after reset.
- R6: The clock edge that would advance the address past DEPTH-1 instead marks the store used up. From then on the address holds and dout_en stays 0 until reset.
- R7: ceo_n is 0 exactly when the chip is selected, reset is inactive and the store is used up. It therefore follows ce_n once the store is used up, and returns to a constant 1 only after reset.
- R8: A write (wr_en high) stores wr_bit at wr_addr on the clock edge only if reset is active on that edge. Otherwise the write is ignored.
- R9: In a chain where each store's ce_n is driven by the previous store's ceo_n, no two stores drive the data line in the same cycle. The shared line carries the concatenated contents in order, one bit per enabled clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on the rising edge |
| rst_oe | input | 1 | Combined reset / output-enable; active level set by RST_ACTIVE_HIGH |
| ce_n | input | 1 | Chip enable, active low |
| wr_en | input | 1 | Content write strobe, honoured only during reset |
| wr_addr | input | AW | Bit address for a content write |
| wr_bit | input | 1 | Bit value for a content write |
| dout | output | 1 | Stored bit at the current address |
| dout_en | output | 1 | Drive enable for dout onto a shared data line |
| ceo_n | output | 1 | Chip-enable-out to the next store in a chain, active low |
| standby | output | 1 | High while the chip is deselected |

## Verification
A wrong address shows up at once on the shared data line as a bit that differs from the loaded image, in the same cycle the bad address is presented. A used-up flag that is set too early, set too late or lost shows up within one cycle as a handoff between chained stores that is early or late: two drive-enables high together, a bit skipped or repeated, or ceo_n at the wrong level. A write that slips through outside reset changes the image, and the next full read-out after a reset shows it. Chip-enable pauses and resets in the middle of the stream are mixed in at random, so that freezing and restarting are both exercised.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  // Output phase of one store, decided from its pins and exhaustion state.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RESET  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_SPENT  = 2'd3
  } cbs_phase_e;

  // Address arithmetic kept here so the counter and any reader agree.
  function automatic logic [31:0] cbs_step(input logic [31:0] a);
    return a + 32'd1;
  endfunction

  function automatic logic cbs_at_end(input logic [31:0] a, input logic [31:0] depth);
    return a == (depth - 32'd1);
  endfunction

endpackage

// File: rtl/cbs_counter.sv
module cbs_counter
  import cbs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          spent,
  output logic          step_ev,
  output logic          wrap_ev
);

  logic at_end;

  assign at_end  = cbs_at_end(32'(addr), 32'(DEPTH));
  assign step_ev = adv & ~spent & ~at_end;
  assign wrap_ev = adv & ~spent & at_end;

  always_ff @(posedge clk) begin
    if (clr) begin
      addr  <= '0;
      spent <= 1'b0;
    end else begin
      if (step_ev) addr  <= AW'(cbs_step(32'(addr)));
      if (wrap_ev) spent <= 1'b1;
    end
  end

endmodule

// File: rtl/cbs_store.sv
module cbs_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic             wbit,
  input  logic [AW-1:0]    raddr,
  output logic             rbit,
  output logic [DEPTH-1:0] image
);

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < 32'(DEPTH))) mem[waddr] <= wbit;
  end

  assign rbit  = mem[raddr];
  assign image = mem;

endmodule

// File: rtl/cbs_pins.sv
module cbs_pins
  import cbs_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic rst_oe,
  input  logic ce_n,
  input  logic spent,
  output logic rst_act,
  output logic adv,
  output logic dout_en,
  output logic ceo_n,
  output logic standby
);

  cbs_phase_e phase;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_high
      assign rst_act = rst_oe;
    end else begin : g_rst_low
      assign rst_act = ~rst_oe;
    end
  endgenerate

  always_comb begin
    if (ce_n)         phase = PH_IDLE;
    else if (rst_act) phase = PH_RESET;
    else if (spent)   phase = PH_SPENT;
    else              phase = PH_ACTIVE;
  end

  assign adv     = (phase == PH_ACTIVE);
  assign dout_en = (phase == PH_ACTIVE);
  assign ceo_n   = (phase != PH_SPENT);
  assign standby = ce_n;

endmodule

// File: rtl/cfg_bitstore.sv
module cfg_bitstore #(
  parameter int DEPTH           = 64,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW             = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_oe,
  input  logic          ce_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          dout,
  output logic          dout_en,
  output logic          ceo_n,
  output logic          standby
);

  logic             rst_act;
  logic             adv;
  logic             spent;
  logic             step_ev;
  logic             wrap_ev;
  logic             wr_ok;
  logic [AW-1:0]    addr;
  logic [DEPTH-1:0] image;

  // Loading is only allowed while the store is held in reset.
  assign wr_ok = wr_en & rst_act;

  cbs_pins #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_pins (
    .rst_oe  (rst_oe),
    .ce_n    (ce_n),
    .spent   (spent),
    .rst_act (rst_act),
    .adv     (adv),
    .dout_en (dout_en),
    .ceo_n   (ceo_n),
    .standby (standby)
  );

  cbs_counter #(.DEPTH(DEPTH), .AW(AW)) u_counter (
    .clk     (clk),
    .clr     (rst_act),
    .adv     (adv),
    .addr    (addr),
    .spent   (spent),
    .step_ev (step_ev),
    .wrap_ev (wrap_ev)
  );

  cbs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_addr),
    .wbit  (wr_bit),
    .raddr (addr),
    .rbit  (dout),
    .image (image)
  );

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_act,
  input logic             ce_n,
  input logic [AW-1:0]    addr,
  input logic             spent,
  input logic             step_ev,
  input logic             wrap_ev,
  input logic [DEPTH-1:0] image,
  input logic             dout_en,
  input logic             ceo_n,
  input logic             standby
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_step: assert property (@(posedge clk) disable iff (!armed || rst_act)
    step_ev |=> addr == AW'($past(addr) + 1'b1));

  a_r3_reset_clears: assert property (@(posedge clk) disable iff (!armed)
    rst_act |=> (addr == '0 && !spent));

  a_r3_reset_pins: assert property (@(posedge clk) disable iff (!armed)
    rst_act |-> (!dout_en && ceo_n));

  a_r4_idle_pins: assert property (@(posedge clk) disable iff (!armed)
    ce_n |-> (!dout_en && ceo_n && standby));

  a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!armed || rst_act)
    ce_n |=> $stable(addr));

  a_r5_no_overlap_ceo: assert property (@(posedge clk) disable iff (!armed)
    dout_en |-> ceo_n);

  a_r6_wrap_stops: assert property (@(posedge clk) disable iff (!armed || rst_act)
    wrap_ev |=> (spent && !dout_en));

  a_r6_spent_hold: assert property (@(posedge clk) disable iff (!armed || rst_act)
    spent |=> (spent && $stable(addr)));

  a_r7_ceo_cause: assert property (@(posedge clk) disable iff (!armed)
    !ceo_n |-> (spent && !ce_n && !rst_act));

  a_r8_no_write: assert property (@(posedge clk) disable iff (!armed)
    !rst_act |=> $stable(image));

endmodule

bind cfg_bitstore cbs_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_act (rst_act),
  .ce_n    (ce_n),
  .addr    (addr),
  .spent   (spent),
  .step_ev (step_ev),
  .wrap_ev (wrap_ev),
  .image   (image),
  .dout_en (dout_en),
  .ceo_n   (ceo_n),
  .standby (standby)
);

// File: tb/cfg_bitstore_bench.sv
module cfg_bitstore_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 64;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst = 1'b1;
  logic          ce_n_a = 1'b0;
  logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_bit = 1'b0;

  logic a_d, a_en, a_ceo, a_sb;
  logic b_d, b_en, b_ceo, b_sb;
  logic l_d, l_en, l_ceo, l_sb;

  // Device A heads the chain, device B follows it.
  cfg_bitstore #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1)) u_cfg_bitstore (
    .clk(clk), .rst_oe(rst), .ce_n(ce_n_a), .wr_en(wr_en_a), .wr_addr(wr_addr),
    .wr_bit(wr_bit), .dout(a_d), .dout_en(a_en), .ceo_n(a_ceo), .standby(a_sb));

  cfg_bitstore #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1)) u_next (
    .clk(clk), .rst_oe(rst), .ce_n(a_ceo), .wr_en(wr_en_b), .wr_addr(wr_addr),
    .wr_bit(wr_bit), .dout(b_d), .dout_en(b_en), .ceo_n(b_ceo), .standby(b_sb));

  // Active-low reset variant mirroring device A (R2).
  cfg_bitstore #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) u_inv (
    .clk(clk), .rst_oe(~rst), .ce_n(ce_n_a), .wr_en(wr_en_a), .wr_addr(wr_addr),
    .wr_bit(wr_bit), .dout(l_d), .dout_en(l_en), .ceo_n(l_ceo), .standby(l_sb));

  logic bus;
  assign bus = a_en ? a_d : b_d;

  int vectors = 0;
  int errors  = 0;
  logic exp_bits [2*D];
  int idx = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (stream index %0d)", tag, act, exp, idx);
    end
  endtask

  // wsel: 0 none, 1 device A (and mirror), 2 device B.
  task automatic step(input logic r, input logic cn, input int wsel,
                      input int waddr, input logic wbit);
    logic ea, eb, ca, cb;
    string t;
    @(negedge clk);
    rst = r; ce_n_a = cn;
    wr_en_a = (wsel == 1); wr_en_b = (wsel == 2);
    wr_addr = AW'(waddr); wr_bit = wbit;
    #1;
    if (r || cn)        begin ea = 0; eb = 0; ca = 1; cb = 1; end
    else if (idx < D)   begin ea = 1; eb = 0; ca = 1; cb = 1; end
    else if (idx < 2*D) begin ea = 0; eb = 1; ca = 0; cb = 1; end
    else                begin ea = 0; eb = 0; ca = 0; cb = 0; end
    t = r ? "R3" : (cn ? "R4" : (idx >= D ? "R6 R7" : "R5"));
    chk("R9 overlap", a_en & b_en, 1'b0);
    chk({t, " dout_en A"}, a_en, ea);
    chk({t, " ceo_n A"}, a_ceo, ca);
    chk("R4 standby A", a_sb, cn);
    chk({t, " dout_en B"}, b_en, eb);
    chk({t, " ceo_n B"}, b_ceo, cb);
    chk("R2 dout_en inverted", l_en, ea);
    chk("R2 ceo_n inverted", l_ceo, ca);
    if (ea || eb) chk("R1 R5 R8 R9 data bit", bus, exp_bits[idx]);
    if (ea) chk("R2 data inverted", l_d, exp_bits[idx]);
    // Model of the coming rising edge.
    if (r) begin
      idx = 0;
      if (wsel == 1) exp_bits[waddr] = wbit;
      if (wsel == 2) exp_bits[D + waddr] = wbit;
    end else if (!cn && idx < 2*D) begin
      idx++;
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < D; i++) begin
      step(1'b1, $urandom_range(0, 1) == 0, 1, i, 1'($urandom));
      step(1'b1, 1'b0, 2, i, 1'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // Reset state and load both stores (R3, R8).
    load_all();
    step(1'b1, 1'b0, 0, 0, 1'b0);
    // Full stream, with writes attempted outside reset that must be ignored (R8).
    for (int i = 0; i < 2*D + 6; i++)
      step(1'b0, 1'b0, $urandom_range(0, 2), $urandom_range(0, D-1), 1'($urandom));
    // After exhaustion, ceo_n follows ce_n (R7).
    step(1'b0, 1'b1, 0, 0, 1'b0);
    step(1'b0, 1'b0, 0, 0, 1'b0);
    // Reset then re-read the whole image: shows any leaked write (R8).
    step(1'b1, 1'b0, 0, 0, 1'b0);
    for (int i = 0; i < 2*D + 3; i++) step(1'b0, 1'b0, 0, 0, 1'b0);
    // Random pauses and mid-stream resets (R1, R4, R3).
    for (int i = 0; i < 900; i++)
      step($urandom_range(0, 99) < 3, $urandom_range(0, 3) == 0, 0, 0, 1'b0);
    // Reload with a new image, then a continuous read-out.
    load_all();
    for (int i = 0; i < 2*D + 4; i++) step(1'b0, 1'b0, 0, 0, 1'b0);
    // Reset with chip deselected still clears the counters (R3, R4).
    step(1'b1, 1'b1, 0, 0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule